// File: doc/BRIEF.md
# Adaptive Dead-Time Optimizer

This block closes a slow control loop around the dead time that a PWM generator inserts between the high-side and low-side gate edges of a power stage. It does not use a fixed worst-case margin. It measures how much shoot-through current the present candidate dead time causes and moves the candidate toward the smallest value that keeps that current negligible.

Switching cycles come in pairs. In a reference cycle the PWM generator applies a wide, safe dead band, so the peak current of that cycle contains no shoot-through. In the trial cycle that follows, the candidate dead time is applied. The block subtracts the reference peak from the trial peak to estimate the shoot-through caused by the candidate timing. It averages this estimate over 2^K pairs so that input and output transients cancel out. It then compares the average with the resolution of the current-sense chain. When the average is below the resolution, the candidate shrinks by one step. Otherwise it grows by one step. The candidate always stays between a programmable floor and ceiling.

The sense front end pulses a strobe once per switching cycle and presents that cycle's peak current with it. The PWM generator reads the dead time to apply in the next cycle and a flag that marks reference cycles.

Top module: `deadtime_tuner`

## Requirements
- R1: After a synchronous active-high reset, ref_cycle_o is 1, dt_cand_o equals the DT_RESET parameter (40), dt_apply_o equals SAFE_DT (200), and with floor 30 and ceiling 50 at_limit_o is 0.
- R2: Each cycle_stb_i pulse toggles ref_cycle_o. The first pulse after reset carries the reference peak. While ref_cycle_o is 1, dt_apply_o equals SAFE_DT. While it is 0, dt_apply_o equals dt_cand_o.
- R3: The estimate for a pair is the trial peak minus the reference peak, and it is zero when the trial peak is not larger.
- R4: Pair estimates are summed over 2^K pairs (K=2, so 4 pairs). Only after the last pair of a group is the sum divided by 2^K (truncated) and used. dt_cand_o does not change inside a group.
- R5: When the group average is strictly less than res_i, dt_cand_o decreases by exactly 1.
- R6: When the group average is greater than or equal to res_i, dt_cand_o increases by exactly 1.
- R7: After an update, dt_cand_o is clamped into [dt_min_i, dt_max_i]. It holds at the ceiling when asked to grow and at the floor when asked to shrink.
- R8: at_limit_o is 1 exactly when dt_cand_o is less than or equal to dt_min_i or greater than or equal to dt_max_i.
- R9: Without a cycle_stb_i pulse, changes on peak_i alter neither ref_cycle_o nor dt_cand_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_stb_i | input | 1 | One-clock pulse per finished switching cycle |
| peak_i | input | PEAK_W (12) | Peak inductor current of the finished cycle |
| res_i | input | PEAK_W (12) | Sense-chain resolution threshold |
| dt_min_i | input | DT_W (8) | Floor of the candidate dead time |
| dt_max_i | input | DT_W (8) | Ceiling of the candidate dead time |
| dt_apply_o | output | DT_W (8) | Dead time the PWM generator applies in the next cycle |
| dt_cand_o | output | DT_W (8) | Present candidate dead time |
| ref_cycle_o | output | 1 | The next cycle is a reference cycle |
| at_limit_o | output | 1 | Candidate is at the floor or the ceiling |

## Verification
The bench drives groups of four identical pairs whose estimates fall below, exactly on, and above the resolution. This separates a strict from a non-strict comparison and checks the one-step moves in both directions. Mixed groups, one large estimate among small ones or one negative difference among positives, have averages on either side of the threshold. They tell a true 4-pair mean apart from a last-sample, maximum, or signed sum. Narrowed floor and ceiling settings show the clamp and the limit flag. Strobe-free cycles with a changing peak show that nothing moves without a strobe.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    localparam int PEAK_W_DEF = 12;
    localparam int DT_W_DEF   = 8;

    typedef enum logic {
        PH_REF   = 1'b0,
        PH_TRIAL = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_e;

endpackage

// File: rtl/dtt_pair_diff.sv
module dtt_pair_diff
    import dtt_pkg::*;
#(
    parameter int PW = PEAK_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [PW-1:0] peak,
    output phase_e        phase,
    output logic          diff_vld,
    output logic [PW-1:0] diff
);

    logic [PW-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_REF;
            ref_q    <= '0;
            diff_vld <= 1'b0;
            diff     <= '0;
        end else begin
            diff_vld <= 1'b0;
            if (stb) begin
                if (phase == PH_REF) begin
                    ref_q <= peak;
                    phase <= PH_TRIAL;
                end else begin
                    diff_vld <= 1'b1;
                    diff     <= (peak > ref_q) ? (peak - ref_q) : '0;
                    phase    <= PH_REF;
                end
            end
        end
    end

    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (rst)
        stb |=> (phase != $past(phase))); // R2

    AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stb && phase == PH_TRIAL && peak <= ref_q) |=> (diff_vld && diff == '0)); // R3

    AST_NO_STB_NO_DIFF: assert property (@(posedge clk) disable iff (rst)
        !stb |=> !diff_vld); // R9

endmodule

// File: rtl/dtt_avg.sv
module dtt_avg
    import dtt_pkg::*;
#(
    parameter int PW = PEAK_W_DEF,
    parameter int K  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          diff_vld,
    input  logic [PW-1:0] diff,
    output logic          avg_vld,
    output logic [PW-1:0] avg
);

    localparam int SW = PW + K;
    localparam int CW = (K > 0) ? K : 1;
    localparam logic [CW-1:0] LAST = CW'((1 << K) - 1);

    logic [SW-1:0] acc_q;
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sum;

    assign sum = acc_q + SW'(diff);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            avg_vld <= 1'b0;
            avg     <= '0;
        end else begin
            avg_vld <= 1'b0;
            if (diff_vld) begin
                if (cnt_q == LAST) begin
                    avg     <= PW'(sum >> K);
                    avg_vld <= 1'b1;
                    acc_q   <= '0;
                    cnt_q   <= '0;
                end else begin
                    acc_q <= sum;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_AVG_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
        avg_vld |-> $past(diff_vld)); // R4

    AST_IDLE_ACC_STABLE: assert property (@(posedge clk) disable iff (rst)
        !diff_vld |=> ($stable(acc_q) && $stable(cnt_q))); // R4

endmodule

// File: rtl/dtt_step.sv
module dtt_step
    import dtt_pkg::*;
#(
    parameter int          PW       = PEAK_W_DEF,
    parameter int          DW       = DT_W_DEF,
    parameter logic [DW-1:0] DT_RESET = DW'(40)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          avg_vld,
    input  logic [PW-1:0] avg,
    input  logic [PW-1:0] res,
    input  logic [DW-1:0] dt_min,
    input  logic [DW-1:0] dt_max,
    output logic [DW-1:0] dt_q
);

    step_e         dir;
    logic [DW:0]   raw;
    logic [DW-1:0] nxt;

    always_comb begin
        if (!avg_vld)       dir = STEP_HOLD;
        else if (avg < res) dir = STEP_DOWN;
        else                dir = STEP_UP;
    end

    always_comb begin
        case (dir)
            STEP_UP:   raw = {1'b0, dt_q} + 1'b1;
            STEP_DOWN: raw = (dt_q == '0) ? '0 : ({1'b0, dt_q} - 1'b1);
            default:   raw = {1'b0, dt_q};
        endcase
        if (raw < {1'b0, dt_min})      nxt = dt_min;
        else if (raw > {1'b0, dt_max}) nxt = dt_max;
        else                           nxt = raw[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                  dt_q <= DT_RESET;
        else if (dir != STEP_HOLD) dt_q <= nxt;
    end

    AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        !avg_vld |=> $stable(dt_q)); // R4

    AST_ONE_LSB: assert property (@(posedge clk) disable iff (rst)
        (avg_vld && dt_q > dt_min && dt_q < dt_max)
        |=> ((dt_q - $past(dt_q)) == DW'(1) || ($past(dt_q) - dt_q) == DW'(1))); // R5

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (avg_vld && dt_min <= dt_max)
        |=> (dt_q >= $past(dt_min) && dt_q <= $past(dt_max))); // R7

endmodule

// File: rtl/deadtime_tuner.sv
module deadtime_tuner
    import dtt_pkg::*;
#(
    parameter int            PEAK_W   = PEAK_W_DEF,
    parameter int            DT_W     = DT_W_DEF,
    parameter int            K        = 2,
    parameter logic [DT_W-1:0] SAFE_DT  = DT_W'(200),
    parameter logic [DT_W-1:0] DT_RESET = DT_W'(40)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_stb_i,
    input  logic [PEAK_W-1:0] peak_i,
    input  logic [PEAK_W-1:0] res_i,
    input  logic [DT_W-1:0]   dt_min_i,
    input  logic [DT_W-1:0]   dt_max_i,
    output logic [DT_W-1:0]   dt_apply_o,
    output logic [DT_W-1:0]   dt_cand_o,
    output logic              ref_cycle_o,
    output logic              at_limit_o
);

    phase_e            phase;
    logic              diff_vld;
    logic [PEAK_W-1:0] diff;
    logic              avg_vld;
    logic [PEAK_W-1:0] avg;
    logic [DT_W-1:0]   cand;

    dtt_pair_diff #(.PW(PEAK_W)) u_pair (
        .clk      (clk),
        .rst      (rst),
        .stb      (cycle_stb_i),
        .peak     (peak_i),
        .phase    (phase),
        .diff_vld (diff_vld),
        .diff     (diff)
    );

    dtt_avg #(.PW(PEAK_W), .K(K)) u_avg (
        .clk      (clk),
        .rst      (rst),
        .diff_vld (diff_vld),
        .diff     (diff),
        .avg_vld  (avg_vld),
        .avg      (avg)
    );

    dtt_step #(.PW(PEAK_W), .DW(DT_W), .DT_RESET(DT_RESET)) u_step (
        .clk     (clk),
        .rst     (rst),
        .avg_vld (avg_vld),
        .avg     (avg),
        .res     (res_i),
        .dt_min  (dt_min_i),
        .dt_max  (dt_max_i),
        .dt_q    (cand)
    );

    assign ref_cycle_o = (phase == PH_REF);
    assign dt_cand_o   = cand;
    assign dt_apply_o  = (phase == PH_REF) ? SAFE_DT : cand;
    assign at_limit_o  = (cand <= dt_min_i) || (cand >= dt_max_i);

    AST_SAFE_ON_REF: assert property (@(posedge clk) disable iff (rst)
        (cycle_stb_i && phase == PH_TRIAL) |=> (dt_apply_o == SAFE_DT)); // R2

endmodule

// File: tb/deadtime_tuner_bench.sv
module deadtime_tuner_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic [11:0] peak = '0;
    logic [11:0] res = 12'd16;
    logic [7:0]  dmin = 8'd30;
    logic [7:0]  dmax = 8'd50;
    logic [7:0]  apply_o, cand_o;
    logic        ref_o, lim_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    deadtime_tuner u_deadtime_tuner (
        .clk(clk), .rst(rst), .cycle_stb_i(stb), .peak_i(peak), .res_i(res),
        .dt_min_i(dmin), .dt_max_i(dmax), .dt_apply_o(apply_o),
        .dt_cand_o(cand_o), .ref_cycle_o(ref_o), .at_limit_o(lim_o)
    );

    // ref peak, trial peak, expected candidate after a group of 4 such pairs
    localparam int TBL[6][3] = '{
        '{100, 100, 39},   // diff 0 below res
        '{100, 120, 40},   // diff 20 above res
        '{200, 216, 41},   // diff 16 equal to res
        '{200, 215, 40},   // diff 15 just below
        '{300, 250, 39},   // negative diff
        '{ 50,  90, 40}    // diff 40
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(int v);
        @(negedge clk);
        stb  = 1'b1;
        peak = 12'(v);
        @(negedge clk);
        stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pair(int r, int t);
        pulse(r);
        pulse(t);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int exp_c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ref_cycle", int'(ref_o), 1);
        check("R1 cand", int'(cand_o), 40);
        check("R1 apply", int'(apply_o), 200);
        check("R1 at_limit", int'(lim_o), 0);

        // R2 alternation and applied value
        pulse(100);
        check("R2 ref after first", int'(ref_o), 0);
        check("R2 apply trial", int'(apply_o), int'(cand_o));
        pulse(100);
        check("R2 ref after second", int'(ref_o), 1);
        check("R2 apply ref", int'(apply_o), 200);
        // complete the first group (diff 0) -> 39
        for (int i = 0; i < 3; i++) pair(100, 100);
        check("R5 first group down", int'(cand_o), 39);

        // R9 peak changes without strobe
        repeat (6) begin
            @(negedge clk);
            peak = peak + 12'd500;
        end
        check("R9 cand hold", int'(cand_o), 39);
        check("R9 ref hold", int'(ref_o), 1);

        // table walk: R3 R4 R5 R6
        exp_c = 39;
        for (int g = 0; g < 6; g++) begin
            for (int p = 0; p < 3; p++) pair(TBL[g][0], TBL[g][1]);
            check("R4 hold inside group", int'(cand_o), exp_c);
            pair(TBL[g][0], TBL[g][1]);
            exp_c = TBL[g][2] - 1;
            check("R3/R5/R6 group result", int'(cand_o), TBL[g][2] - 1);
        end
        // table values were written for a start of 40; shift absorbed above
        exp_c = int'(cand_o);

        // averaging: diffs 0,0,0,60 -> 15 -> down
        pair(100, 100); pair(100, 100); pair(100, 100); pair(100, 160);
        check("R4 mean 15 steps down", int'(cand_o), exp_c - 1);
        exp_c = exp_c - 1;
        // diffs 0,0,4,60 -> 16 -> up
        pair(100, 100); pair(100, 100); pair(100, 104); pair(100, 160);
        check("R6 mean 16 steps up", int'(cand_o), exp_c + 1);
        exp_c = exp_c + 1;
        // diffs -60(->0),30,30,4 -> 16 -> up
        pair(100, 40); pair(100, 130); pair(100, 130); pair(100, 104);
        check("R3 negative clamped in mean", int'(cand_o), exp_c + 1);
        exp_c = exp_c + 1;

        // R7 / R8 ceiling
        dmax = 8'(exp_c + 1);
        @(negedge clk);
        check("R8 below ceiling", int'(lim_o), 0);
        for (int i = 0; i < 4; i++) pair(10, 60);
        check("R6 up to ceiling", int'(cand_o), exp_c + 1);
        check("R8 at ceiling", int'(lim_o), 1);
        for (int i = 0; i < 4; i++) pair(10, 60);
        check("R7 held at ceiling", int'(cand_o), exp_c + 1);
        exp_c = exp_c + 1;

        // R7 / R8 floor
        dmax = 8'd50;
        dmin = 8'(exp_c - 1);
        for (int i = 0; i < 4; i++) pair(10, 10);
        check("R5 down to floor", int'(cand_o), exp_c - 1);
        check("R8 at floor", int'(lim_o), 1);
        for (int i = 0; i < 4; i++) pair(10, 10);
        check("R7 held at floor", int'(cand_o), exp_c - 1);
        dmin = 8'd30;
        @(negedge clk);
        check("R8 cleared in range", int'(lim_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule